// File: doc/BRIEF.md
# Anti-Token Cancellation Pipeline

This block is a linear chain of pipeline slots that carries data tokens from a producer at the head to a consumer at the tail. The consumer can also carry cancel requests back the other way. A cancel is raised when the consuming logic has already formed its result and no longer needs the next input. It is not stalled until that input shows up. The cancel is accepted at the tail right away, which acknowledges the missing input early. It then becomes an anti-token that walks back toward the producer, one slot per clock.

When an anti-token and a token meet, both disappear. They meet either by sitting in adjacent slots, or by both heading for the same empty slot in one cycle. Neither item can ever pass the other, so no arbitration element is needed. An anti-token that reaches the head without meeting a token waits there and raises a cancel indication to the producer. The producer's next token is then accepted and silently discarded.

The data ends follow valid/ready rules. A token moves at `in_valid && in_ready` and at `out_valid && out_ready`, and a cancel moves at `cancel_req && cancel_ready`. A producer must hold `in_valid` and `in_data` until the transfer, and the consumer must hold `cancel_req` until it is accepted. No ready output depends on any input in the same cycle. DEPTH must be at least 2.

Top module: `atok_chain`

## Requirements
- R1: After reset every slot is empty: in_ready=1, cancel_ready=1, out_valid=0, up_cancel=0.
- R2: A token accepted into an empty chain shows at out_valid DEPTH-1 clock edges after the edge that accepted it, with in_data unchanged. Tokens are delivered in the order they were accepted.
- R3: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data stays stable. in_ready is 0 exactly while the head slot holds a token.
- R4: cancel_ready is 1 exactly when the tail slot is empty, so it is 0 while a token waits at out_valid. An accepted cancel places an anti-token in the tail, and out_valid is 0 on the following cycle.
- R5: An anti-token advances one slot toward the head per clock while the slot ahead is free. A cancel accepted into an empty chain raises up_cancel DEPTH-1 edges after its acceptance edge.
- R6: up_cancel stays 1 until in_valid is seen. While up_cancel=1, in_ready is 1. The next token is accepted and destroyed, up_cancel falls on the next cycle, and that token never reaches out_valid.
- R7: A token and an anti-token that meet are both removed on that edge. They meet in adjacent slots, or when both aim for the same empty slot. Each accepted cancel removes exactly one token: the oldest one not yet delivered or already claimed.
- R8: Once the chain has drained, the number of delivered tokens equals accepted tokens minus accepted cancels, and all delivered data appear in acceptance order.
- R9: An item never moves into a slot held by an item travelling the same way, and it does not move into a slot that is being vacated in the same cycle. A free-flowing stream is therefore delivered one token every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a token |
| in_data | input | DATA_W | Token payload from the producer |
| in_ready | output | 1 | Head can take a token this cycle |
| up_cancel | output | 1 | An anti-token waits at the head; the producer's next token will be discarded |
| out_valid | output | 1 | A token waits at the tail |
| out_data | output | DATA_W | Payload of the tail token |
| out_ready | input | 1 | Consumer takes the tail token |
| cancel_req | input | 1 | Consumer cancels its next expected token |
| cancel_ready | output | 1 | Tail can accept a cancel this cycle |

## Verification
Every cycle, the assertions check the local movement rules. Tokens and anti-tokens step one slot into free space, and an adjacent opposing pair always vanishes together. No slot is filled from both sides at once, and an anti-token is held at the head until a token arrives. Output hold under back-pressure and the blocking of delivery after an accepted cancel are also checked every cycle. Only the bench's scenarios can show end-to-end properties. These are the exact latencies through the chain, which token a given cancel destroys, and the throughput of one token per two cycles. The conservation of delivered = accepted − cancelled under random interleavings of tokens, cancels and consumer stalls is also shown only by the bench.

// File: rtl/atok_pkg.sv
package atok_pkg;

  // Occupancy of one pipeline slot
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'b00,
    SLOT_TOK   = 2'b01,
    SLOT_ANTI  = 2'b10
  } slot_e;

endpackage

// File: rtl/atok_fate.sv
// Decides, for one position of the extended chain, whether its item is
// annihilated this cycle and whether it moves on. A token looks downstream,
// an anti-token looks upstream, each at most two positions away.
module atok_fate
  import atok_pkg::*;
#(
  parameter bit HEAD_SLOT = 1'b0,
  parameter bit TAIL_SLOT = 1'b0
) (
  input  slot_e l2,
  input  slot_e l1,
  input  slot_e me,
  input  slot_e r1,
  input  slot_e r2,
  input  logic  out_ready,
  output logic  kill,
  output logic  leave
);

  always_comb begin
    kill  = 1'b0;
    leave = 1'b0;
    case (me)
      SLOT_TOK: begin
        // meets an anti-token next door, or both head for the same hole
        kill  = (r1 == SLOT_ANTI) || ((r1 == SLOT_EMPTY) && (r2 == SLOT_ANTI));
        leave = TAIL_SLOT ? out_ready : (r1 == SLOT_EMPTY);
      end
      SLOT_ANTI: begin
        kill  = (l1 == SLOT_TOK) || ((l1 == SLOT_EMPTY) && (l2 == SLOT_TOK));
        leave = HEAD_SLOT ? 1'b0 : (l1 == SLOT_EMPTY);
      end
      default: begin
        kill  = 1'b0;
        leave = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/atok_cell.sv
// One pipeline slot: occupancy register plus payload register.
module atok_cell
  import atok_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              leave,
  input  logic              tok_in,
  input  logic              anti_in,
  input  logic [DATA_W-1:0] din,
  output slot_e             st_o,
  output logic [DATA_W-1:0] dat_o
);

  slot_e st_q, st_d;
  logic [DATA_W-1:0] dat_q;

  always_comb begin
    if (st_q == SLOT_EMPTY) begin
      if (tok_in)       st_d = SLOT_TOK;
      else if (anti_in) st_d = SLOT_ANTI;
      else              st_d = SLOT_EMPTY;
    end else if (kill || leave) begin
      st_d = SLOT_EMPTY;
    end else begin
      st_d = st_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SLOT_EMPTY;
      dat_q <= '0;
    end else begin
      st_q <= st_d;
      if (tok_in) dat_q <= din;
    end
  end

  assign st_o  = st_q;
  assign dat_o = dat_q;

  AST_SINGLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok_in && anti_in)); // R7

  AST_FILL_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in || anti_in) |-> (st_q == SLOT_EMPTY)); // R9

endmodule

// File: rtl/atok_chain.sv
module atok_chain
  import atok_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              up_cancel,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              cancel_req,
  output logic              cancel_ready
);

  // Extended position p: 0 = incoming token, 1..DEPTH = slots 0..DEPTH-1,
  // DEPTH+1 = incoming anti-token. Stored with an offset of 2 and empty padding.
  localparam int NPOS = DEPTH + 2;
  localparam int EXT  = DEPTH + 6;

  slot_e             st   [DEPTH];
  logic [DATA_W-1:0] dat  [DEPTH];
  logic [DATA_W-1:0] dsrc [DEPTH+1];
  slot_e             ext  [EXT];
  logic              kill [NPOS];
  logic              leave[NPOS];
  logic              in_acc, cancel_acc;

  assign in_ready     = (st[0] != SLOT_TOK);
  assign up_cancel    = (st[0] == SLOT_ANTI);
  assign out_valid    = (st[DEPTH-1] == SLOT_TOK);
  assign out_data     = dat[DEPTH-1];
  assign cancel_ready = (st[DEPTH-1] == SLOT_EMPTY);
  assign in_acc       = in_valid && in_ready;
  assign cancel_acc   = cancel_req && cancel_ready;

  always_comb begin
    for (int i = 0; i < EXT; i++) ext[i] = SLOT_EMPTY;
    ext[2] = in_acc ? SLOT_TOK : SLOT_EMPTY;
    for (int k = 0; k < DEPTH; k++) ext[k+3] = st[k];
    ext[DEPTH+3] = cancel_acc ? SLOT_ANTI : SLOT_EMPTY;
  end

  assign dsrc[0] = in_data;

  for (genvar p = 0; p < NPOS; p++) begin : g_fate
    atok_fate #(
      .HEAD_SLOT(p == 1),
      .TAIL_SLOT(p == DEPTH)
    ) u_fate (
      .l2       (ext[p]),
      .l1       (ext[p+1]),
      .me       (ext[p+2]),
      .r1       (ext[p+3]),
      .r2       (ext[p+4]),
      .out_ready(out_ready),
      .kill     (kill[p]),
      .leave    (leave[p])
    );
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic tok_in, anti_in;
    // token from upstream position k survives and steps in
    assign tok_in  = (ext[k+2] == SLOT_TOK)  && leave[k]   && !kill[k];
    // anti-token from downstream position k+2 survives and steps in
    assign anti_in = (ext[k+4] == SLOT_ANTI) && leave[k+2] && !kill[k+2];

    atok_cell #(.DATA_W(DATA_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill   (kill[k+1]),
      .leave  (leave[k+1]),
      .tok_in (tok_in),
      .anti_in(anti_in),
      .din    (dsrc[k]),
      .st_o   (st[k]),
      .dat_o  (dat[k])
    );
    assign dsrc[k+1] = dat[k];
  end

  // ---------------------------------------------------------------- checks
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R3

  AST_CANCEL_BLOCKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_acc |=> !out_valid); // R4

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cancel && !in_valid) |=> up_cancel); // R6

  AST_HEAD_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cancel && in_valid) |=> (!up_cancel && in_ready)); // R6

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_pair_chk
    AST_PAIR_ANNIHILATE: assert property (@(posedge clk) disable iff (!rst_n)
      (st[k] == SLOT_TOK && st[k+1] == SLOT_ANTI)
      |=> (st[k] == SLOT_EMPTY && st[k+1] == SLOT_EMPTY)); // R7
  end

  for (genvar k = 0; k < DEPTH - 2; k++) begin : g_tok_chk
    AST_TOKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st[k] == SLOT_TOK && st[k+1] == SLOT_EMPTY && st[k+2] != SLOT_ANTI)
      |=> (st[k+1] == SLOT_TOK && dat[k+1] == $past(dat[k]))); // R2
  end

  for (genvar k = 2; k < DEPTH; k++) begin : g_anti_chk
    AST_ANTI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st[k] == SLOT_ANTI && st[k-1] == SLOT_EMPTY && st[k-2] != SLOT_TOK)
      |=> (st[k-1] == SLOT_ANTI)); // R5
  end

endmodule

// File: tb/atok_chain_bench.sv
`timescale 1ns/1ps
module atok_chain_bench;
  localparam int DEPTH  = 6;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              in_valid, in_ready, up_cancel;
  logic [DATA_W-1:0] in_data, out_data;
  logic              out_valid, out_ready, cancel_req, cancel_ready;

  atok_chain #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_atok_chain (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .up_cancel(up_cancel),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .cancel_req(cancel_req), .cancel_ready(cancel_ready)
  );

  int errors = 0, checks = 0, cyc = 0;
  int owed = 0, n_in = 0, n_del = 0, n_cxl = 0;
  int rdy_pct = 100;
  bit rand_rdy = 1'b0;
  bit done = 1'b0;
  logic [DATA_W-1:0] next_id = '0;
  logic [DATA_W-1:0] last_out = '0;
  logic [DATA_W-1:0] exp_q[$];
  int del_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: samples handshakes 1 ns after the falling edge.
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (in_valid && in_ready) begin
        n_in++;
        if (owed > 0) owed--;          // a waiting anti-token eats it (R6)
        else exp_q.push_back(in_data);
      end
      if (cancel_req && cancel_ready) begin
        n_cxl++;
        if (exp_q.size() > 0) void'(exp_q.pop_front()); // oldest claimed (R7)
        else owed++;
      end
      if (out_valid && out_ready) begin
        n_del++;
        last_out = out_data;
        del_cyc.push_back(cyc);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "delivery of a cancelled token", out_data, -1);
        end else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R8", "delivered data order", out_data, e);
        end
      end
    end
  end

  always @(negedge clk) if (rand_rdy) out_ready <= ($urandom_range(99) < rdy_pct);

  // Driver: offers n tokens with sequential payloads (valid/ready held)
  task automatic send(input int n, input int idle_pct);
    for (int i = 0; i < n; i++) begin
      while ($urandom_range(99) < idle_pct) @(negedge clk);
      in_valid = 1'b1;
      in_data  = next_id;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      next_id++;
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic cancel(input int n, input int idle_pct);
    for (int i = 0; i < n; i++) begin
      while ($urandom_range(99) < idle_pct) @(negedge clk);
      cancel_req = 1'b1;
      #1;
      while (!cancel_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      cancel_req = 1'b0;
    end
  endtask

  task automatic drain_and_check(input string tag);
    int m;
    m = owed;
    if (m > 0) send(m, 0);
    rand_rdy = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (4 * DEPTH + 10) @(negedge clk);
    chk(n_del == n_in - n_cxl, "R8", {tag, " delivered = accepted - cancels"}, n_del, n_in - n_cxl);
    chk(exp_q.size() == 0, "R8", {tag, " tokens left undelivered"}, exp_q.size(), 0);
    chk(owed == 0, "R7", {tag, " cancels left unmatched"}, owed, 0);
    chk(!up_cancel && !out_valid, "R8", {tag, " chain idle after drain"}, {up_cancel, out_valid}, 0);
  endtask

  initial begin
    int k;
    bit seen_out, seen_up;
    logic [DATA_W-1:0] id0;
    int d0;
    in_valid = 1'b0; in_data = '0; cancel_req = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(cancel_ready == 1'b1, "R1", "cancel_ready after reset", cancel_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(up_cancel == 1'b0, "R1", "up_cancel after reset", up_cancel, 0);

    // R2 latency, R3 hold, R4 cancel blocked by waiting token
    id0 = next_id;
    send(1, 0);
    k = 0;
    while (!out_valid && k < 100) begin @(negedge clk); k++; end
    chk(k == DEPTH - 1, "R2", "token latency in edges", k, DEPTH - 1);
    chk(out_data == id0, "R2", "payload intact", out_data, id0);
    chk(cancel_ready == 1'b0, "R4", "cancel_ready with token at tail", cancel_ready, 0);
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == id0, "R3", "tail token held under back-pressure", out_data, id0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && cancel_ready, "R4", "tail empty after delivery", {out_valid, cancel_ready}, 1);

    // R5 anti-token travel, R6 head hold and silent absorption
    cancel(1, 0);
    k = 0;
    while (!up_cancel && k < 100) begin @(negedge clk); k++; end
    chk(k == DEPTH - 1, "R5", "anti-token latency in edges", k, DEPTH - 1);
    repeat (3) @(negedge clk);
    chk(up_cancel == 1'b1, "R6", "up_cancel held without in_valid", up_cancel, 1);
    chk(in_ready == 1'b1, "R6", "in_ready while up_cancel", in_ready, 1);
    out_ready = 1'b1;
    d0 = n_del;
    send(1, 0);
    chk(up_cancel == 1'b0, "R6", "up_cancel falls after absorption", up_cancel, 0);
    seen_out = 1'b0;
    repeat (2 * DEPTH) begin @(negedge clk); if (out_valid) seen_out = 1'b1; end
    chk(!seen_out && n_del == d0, "R6", "absorbed token never delivered", n_del - d0, 0);

    // R7 mid-chain collision
    send(1, 0);
    cancel(1, 0);
    seen_out = 1'b0; seen_up = 1'b0;
    repeat (2 * DEPTH) begin
      @(negedge clk);
      if (out_valid) seen_out = 1'b1;
      if (up_cancel) seen_up = 1'b1;
    end
    chk(!seen_out, "R7", "collided token not delivered", seen_out, 0);
    chk(!seen_up, "R7", "collided anti-token not at head", seen_up, 0);
    id0 = next_id;
    d0 = n_del;
    send(1, 0);
    repeat (2 * DEPTH) @(negedge clk);
    chk(n_del == d0 + 1 && last_out == id0, "R7", "token after collision delivered", last_out, id0);

    // R7 cancel claims the oldest undelivered token
    out_ready = 1'b0;
    id0 = next_id;
    d0 = n_del;
    send(2, 0);
    cancel(1, 0);
    out_ready = 1'b1;
    repeat (3 * DEPTH) @(negedge clk);
    chk(n_del == d0 + 1, "R7", "one of two tokens survives", n_del - d0, 1);
    chk(last_out == id0 + 1, "R7", "younger token survives", last_out, id0 + 1);

    // R9 free-flowing throughput
    del_cyc.delete();
    send(6, 0);
    repeat (3 * DEPTH) @(negedge clk);
    chk(del_cyc.size() == 6, "R9", "stream deliveries", del_cyc.size(), 6);
    for (int i = 1; i < 6 && i < del_cyc.size(); i++)
      chk(del_cyc[i] - del_cyc[i-1] == 2, "R9", "delivery spacing", del_cyc[i] - del_cyc[i-1], 2);

    // R8 random interleavings
    rand_rdy = 1'b1; rdy_pct = 70;
    fork
      send(200, 40);
      cancel(60, 80);
    join
    drain_and_check("mix1");

    rand_rdy = 1'b1; rdy_pct = 40;
    fork
      send(120, 20);
      cancel(90, 30);
    join
    drain_and_check("mix2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule